// File: doc/BRIEF.md
# Decode-Stage Latency Interlock

This block lives in the decode stage of an in-order pipeline that has an integer unit and fully pipelined floating-point units. Every cycle it looks at the instruction waiting in decode: its class and its three register fields. It compares the source registers against a short history of recently issued producers, and it holds the instruction back until each operand can be reached through forwarding. How many cycles a consumer must wait is fixed by a table that is indexed by the class of the producer and by the role of the operand in the consumer.

Issue follows a valid/ready handshake with fetch, and an issue pulse marks every cycle in which an instruction leaves decode. A cycle in which nothing issues, because of a stall or because fetch offers nothing, puts a bubble into the history, and that bubble ages every producer by one cycle. Branches are resolved in decode and have one delay slot. The block flags the instruction that sits in that slot. That instruction always executes, so the block never squashes it.

Top module: `latency_interlock`

## Requirements
- R1: After reset the history is empty: `dec_ready` is 1, and `stall`, `issue` and `delay_slot` are 0.
- R2: Class encoding on `dec_class`: 0 none, 1 integer ALU (writes integer rd, reads integer rs1 and rs2), 2 FP ALU (writes FP rd, reads FP rs1 and rs2), 3 FP load (writes FP rd, reads integer base rs1), 4 FP store (reads integer base rs1 and FP data rs2), 5 branch (compares integer rs1 and rs2), 6 and 7 act as none. `issue` = `dec_valid` and `dec_ready`; `stall` = `dec_valid` and not `dec_ready`. Every cycle without an issue ages the history by one cycle.
- R3: An FP ALU result read by an FP ALU operand needs 3 cycles between the two: the consumer issues no earlier than 4 cycles after its producer. Unrelated instructions in between count toward the wait.
- R4: An FP ALU result read as store data (rs2 of class 4) needs 2 stall cycles when the store directly follows it.
- R5: An FP load result read by an FP ALU operand needs 1 stall cycle. Read as store data, it needs none.
- R6: An integer ALU result read by a branch compare needs 1 stall cycle. Read by any other integer operand (ALU, load base, store base), it needs none.
- R7: The integer and FP register files are separate. A producer blocks only reads of the same register number in its own file.
- R8: An integer ALU write to register 0 never creates a dependency.
- R9: Once a branch issues, `delay_slot` is 1 while the next instruction is valid in decode, including its stall cycles. It drops once that instruction issues.
- R10: Back-to-back FP ALU operations that share no registers issue without any stall.
- R11: Every producer still in the history is checked, including one whose register has since been overwritten by a younger producer. The longest remaining wait decides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Instruction present in decode |
| dec_class | input | 3 | Instruction class (R2 encoding) |
| dec_rd | input | REG_W | Destination register |
| dec_rs1 | input | REG_W | First source register |
| dec_rs2 | input | REG_W | Second source register |
| dec_ready | output | 1 | No interlock against the instruction in decode |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Valid instruction is being held |
| delay_slot | output | 1 | Instruction in decode sits in a branch delay slot |

## Verification
The hardest situation to reach is a consumer that matches two in-flight producers of the same register with different latencies. In that case the older, superseded FP ALU result has to keep the stall going after the younger load has cleared. The stimulus issues an FP ALU and then an FP load to the same register, followed at once by an FP ALU reader, and expects exactly two stall cycles. A delay-slot instruction that itself stalls is driven the same way, so that the slot flag is seen to persist across the bubbles. Idle gaps from fetch are mixed in to show that bubbles age the producers.

// File: rtl/latency_interlock.sv
`timescale 1ns/1ps
module latency_interlock #(
  parameter int REG_W = 5,
  parameter int HIST  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [2:0]       dec_class,
  input  logic [REG_W-1:0] dec_rd,
  input  logic [REG_W-1:0] dec_rs1,
  input  logic [REG_W-1:0] dec_rs2,
  output logic             dec_ready,
  output logic             issue,
  output logic             stall,
  output logic             delay_slot
);
  localparam logic [2:0] C_INT = 3'd1, C_FOP = 3'd2, C_FLD = 3'd3, C_FST = 3'd4, C_BR = 3'd5;
  localparam logic [2:0] U_NONE = 3'd0, U_INT = 3'd1, U_BR = 3'd2, U_FOP = 3'd3, U_STD = 3'd4;
  localparam logic [1:0] K_INT = 2'd0, K_FOP = 2'd1, K_FLD = 2'd2;

  function automatic logic use_fp(input logic [2:0] u);
    return (u == U_FOP) || (u == U_STD);
  endfunction

  function automatic int need(input logic [1:0] kind, input logic [2:0] u);
    int n;
    n = 0;
    case (kind)
      K_FOP:   n = (u == U_FOP) ? 3 : (u == U_STD) ? 2 : 0;
      K_FLD:   n = (u == U_FOP) ? 1 : 0;
      default: n = (u == U_BR)  ? 1 : 0;
    endcase
    return n;
  endfunction

  logic [HIST-1:0] h_vld, h_fp, hit;
  logic [1:0]       h_kind [HIST];
  logic [REG_W-1:0] h_rd   [HIST];
  logic [2:0] u1, u2;
  logic prod_en, prod_fp, after_br;
  logic [1:0] prod_kind;

  always_comb begin
    u1 = U_NONE;
    u2 = U_NONE;
    case (dec_class)
      C_INT: begin u1 = U_INT; u2 = U_INT; end
      C_FOP: begin u1 = U_FOP; u2 = U_FOP; end
      C_FLD: u1 = U_INT;
      C_FST: begin u1 = U_INT; u2 = U_STD; end
      C_BR:  begin u1 = U_BR;  u2 = U_BR;  end
      default: ;
    endcase
  end

  for (genvar k = 0; k < HIST; k++) begin : g_hit
    logic m1, m2;
    assign m1 = (u1 != U_NONE) && (h_fp[k] == use_fp(u1)) && (h_rd[k] == dec_rs1)
                && (k < need(h_kind[k], u1));
    assign m2 = (u2 != U_NONE) && (h_fp[k] == use_fp(u2)) && (h_rd[k] == dec_rs2)
                && (k < need(h_kind[k], u2));
    assign hit[k] = h_vld[k] && (m1 || m2);
  end

  assign dec_ready  = ~|hit;
  assign issue      = dec_valid & dec_ready;
  assign stall      = dec_valid & ~dec_ready;
  assign delay_slot = dec_valid & after_br;

  always_comb begin
    prod_en   = 1'b0;
    prod_fp   = 1'b0;
    prod_kind = K_INT;
    case (dec_class)
      C_INT: prod_en = (dec_rd != '0);
      C_FOP: begin prod_en = 1'b1; prod_fp = 1'b1; prod_kind = K_FOP; end
      C_FLD: begin prod_en = 1'b1; prod_fp = 1'b1; prod_kind = K_FLD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_vld    <= '0;
      h_fp     <= '0;
      after_br <= 1'b0;
      for (int k = 0; k < HIST; k++) begin
        h_kind[k] <= K_INT;
        h_rd[k]   <= '0;
      end
    end else begin
      h_vld[0]  <= issue & prod_en;
      h_fp[0]   <= prod_fp;
      h_kind[0] <= prod_kind;
      h_rd[0]   <= dec_rd;
      for (int k = 1; k < HIST; k++) begin
        h_vld[k]  <= h_vld[k-1];
        h_fp[k]   <= h_fp[k-1];
        h_kind[k] <= h_kind[k-1];
        h_rd[k]   <= h_rd[k-1];
      end
      if (issue) after_br <= (dec_class == C_BR);
    end
  end
endmodule

// File: rtl/latency_interlock_chk.sv
`timescale 1ns/1ps
module latency_interlock_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic [2:0]       dec_class,
  input logic [REG_W-1:0] dec_rd,
  input logic [REG_W-1:0] dec_rs1,
  input logic [REG_W-1:0] dec_rs2,
  input logic             dec_ready,
  input logic             issue,
  input logic             stall,
  input logic             delay_slot
);
  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (dec_valid && !issue));

  a_r3_fop_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_class == 3'd2) ##1
    (dec_valid && dec_class == 3'd2 && dec_rs1 == $past(dec_rd)) |-> stall);

  a_r6_branch_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_class == 3'd1 && dec_rd != '0) ##1
    (dec_valid && dec_class == 3'd5 && dec_rs1 == $past(dec_rd)) |-> stall);

  a_r9_slot_set: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_class == 3'd5) |=> (!dec_valid || delay_slot));

  a_r9_slot_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_class != 3'd5) |=> !delay_slot);

  a_r2_none_free: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == 3'd0) |-> issue);
endmodule

bind latency_interlock latency_interlock_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
  .dec_rd(dec_rd), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_ready(dec_ready),
  .issue(issue), .stall(stall), .delay_slot(delay_slot));

// File: tb/sim_latency_interlock.sv
`timescale 1ns/1ps
module sim_latency_interlock;
  localparam int RW = 5;
  localparam int NONE = 0, INT = 1, FOP = 2, FLD = 3, FST = 4, BR = 5;

  logic clk = 0, rst_n = 0, dec_valid = 0;
  logic [2:0] dec_class = '0;
  logic [RW-1:0] dec_rd = '0, dec_rs1 = '0, dec_rs2 = '0;
  logic dec_ready, issue, stall, delay_slot;

  latency_interlock #(.REG_W(RW), .HIST(3)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
    .dec_rd(dec_rd), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_ready(dec_ready),
    .issue(issue), .stall(stall), .delay_slot(delay_slot));

  always #4 clk = ~clk;

  typedef struct { bit fp; int kind; int rd; int t; } prod_t;
  prod_t hist[$];
  int now = 0;
  bit m_after_br = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // operand roles: 0 none, 1 int, 2 branch compare, 3 FP ALU, 4 store data
  function automatic int role(input int cls, input int slot);
    case (cls)
      INT: return 1;
      FOP: return 3;
      FLD: return slot == 1 ? 1 : 0;
      FST: return slot == 1 ? 1 : 4;
      BR:  return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int wait_of(input int kind, input int r);
    if (kind == FOP) return r == 3 ? 3 : (r == 4 ? 2 : 0);
    if (kind == FLD) return r == 3 ? 1 : 0;
    return r == 2 ? 1 : 0;
  endfunction

  function automatic bit blocked(input int cls, input int rs1, input int rs2);
    bit b = 0;
    foreach (hist[i]) begin
      int d = now - hist[i].t;
      for (int s = 1; s <= 2; s++) begin
        int r = role(cls, s);
        int src = (s == 1) ? rs1 : rs2;
        bit rfp = (r == 3) || (r == 4);
        if (r != 0 && rfp == hist[i].fp && src == hist[i].rd && d <= wait_of(hist[i].kind, r))
          b = 1;
      end
    end
    return b;
  endfunction

  task automatic cycle(input string tag, input bit v, input int cls, input int rd,
                       input int rs1, input int rs2, output bit issued);
    bit blk, e_issue;
    @(negedge clk);
    dec_valid = v; dec_class = cls[2:0]; dec_rd = rd[RW-1:0];
    dec_rs1 = rs1[RW-1:0]; dec_rs2 = rs2[RW-1:0];
    #1;
    blk = blocked(cls, rs1, rs2);
    e_issue = v && !blk;
    chk({tag, " ready"}, dec_ready, !blk);
    chk({tag, " issue"}, issue, e_issue);
    chk({tag, " stall"}, stall, v && blk);
    chk({tag, " slot"}, delay_slot, v && m_after_br);
    @(posedge clk);
    if (e_issue) begin
      if (cls == FOP || cls == FLD || (cls == INT && rd != 0))
        hist.push_back('{fp: (cls != INT), kind: cls, rd: rd, t: now});
      m_after_br = (cls == BR);
    end
    now++;
    while (hist.size() > 8) void'(hist.pop_front());
    issued = e_issue;
  endtask

  task automatic send(input string tag, input int cls, input int rd, input int rs1,
                      input int rs2, output int stalls);
    bit iss = 0;
    stalls = 0;
    for (int n = 0; n < 20 && !iss; n++) begin
      cycle(tag, 1, cls, rd, rs1, rs2, iss);
      if (!iss) stalls++;
    end
  endtask

  task automatic idle(input int n);
    bit iss;
    for (int i = 0; i < n; i++) cycle("idle", 0, NONE, 0, 0, 0, iss);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 ready", dec_ready, 1);
    chk("R1 stall", stall, 0);
    chk("R1 issue", issue, 0);
    chk("R1 slot", delay_slot, 0);

    // R3 adjacent FP ALU chain
    send("R3 p", FOP, 2, 20, 21, s);
    send("R3 c", FOP, 3, 2, 22, s);  chk("R3 stalls adjacent", s, 3);
    idle(4);
    // R3 with an unrelated instruction between
    send("R3 p2", FOP, 4, 20, 21, s);
    send("R3 gap", NONE, 0, 0, 0, s);
    send("R3 c2", FOP, 5, 22, 4, s); chk("R3 stalls with gap", s, 2);
    idle(4);
    // R4 FP ALU to store data
    send("R4 p", FOP, 6, 20, 21, s);
    send("R4 c", FST, 0, 9, 6, s);   chk("R4 stalls", s, 2);
    idle(4);
    // R5 load to FP ALU and to store data
    send("R5 p", FLD, 8, 1, 0, s);
    send("R5 c", FOP, 9, 8, 22, s);  chk("R5 load to fop", s, 1);
    send("R5 p2", FLD, 10, 1, 0, s);
    send("R5 c2", FST, 0, 1, 10, s); chk("R5 load to store", s, 0);
    idle(4);
    // R6 integer result to branch and to other integer reads
    send("R6 p", INT, 3, 1, 2, s);
    send("R6 br", BR, 0, 3, 7, s);   chk("R6 branch", s, 1);
    send("R6 slot", NONE, 0, 0, 0, s);
    send("R6 p2", INT, 4, 1, 2, s);
    send("R6 ld", FLD, 11, 4, 0, s); chk("R6 load base", s, 0);
    send("R6 p3", INT, 5, 1, 2, s);
    send("R6 alu", INT, 6, 1, 5, s); chk("R6 alu", s, 0);
    idle(4);
    // R7 separate files
    send("R7 p", FOP, 12, 20, 21, s);
    send("R7 c", INT, 14, 12, 12, s); chk("R7 fp vs int", s, 0);
    send("R7 p2", INT, 13, 1, 2, s);
    send("R7 c2", FOP, 15, 13, 13, s); chk("R7 int vs fp", s, 0);
    idle(4);
    // R8 register zero
    send("R8 p", INT, 0, 1, 2, s);
    send("R8 br", BR, 0, 0, 0, s);   chk("R8 r0 branch", s, 0);
    send("R8 slot", NONE, 0, 0, 0, s);
    idle(4);
    // R10 independent FP ALU stream
    for (int i = 0; i < 4; i++) begin
      send("R10 fop", FOP, 1 + i, 20 + i, 24 + i, s);
      chk("R10 no stall", s, 0);
    end
    idle(4);
    // R11 superseded producer still counted
    send("R11 p1", FOP, 14, 20, 21, s);
    send("R11 p2", FLD, 14, 1, 0, s);
    send("R11 c", FOP, 16, 14, 22, s); chk("R11 longest wait", s, 2);
    idle(4);
    // R9 delay slot that stalls
    send("R9 p", FOP, 16, 20, 21, s);
    send("R9 br", BR, 0, 20, 21, s);
    send("R9 slot", FOP, 17, 16, 22, s); chk("R9 slot stalls", s, 2);
    #1;
    chk("R9 slot cleared", delay_slot, 0);
    // R2 idle bubbles age producers
    send("R2 p", FOP, 18, 20, 21, s);
    idle(3);
    send("R2 c", FOP, 19, 18, 18, s); chk("R2 bubbles count", s, 0);
    idle(2);
    finish_up();
  end
endmodule